// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns bytes waiting in an external transmit FIFO into asynchronous serial characters on a single TX line. A seven-bit line-control value sets the character format: how many data bits are sent, whether a parity bit follows and how it is computed, how long the stop period lasts, and whether the line is held low as a break. All bit timing comes from a one-cycle enable pulse at sixteen times the bit rate. The baud divider is outside the block.

The FIFO shows its head byte and its occupancy. The block takes a byte by pulsing a pop strobe in the same cycle that it latches that byte and the current format into its shifter. It reports whether the holding side is empty and whether the whole transmitter is empty. It also drives an active-low DMA transmit-ready signal that follows one of two rules, selected by a mode input.

Top module: `serial_char_tx`

## Requirements
- R1: `lcr_cfg[1:0]` sets the number of data bits to 5, 6, 7 or 8 (value plus five). Each character starts with one low start bit, followed by the data bits with the least significant bit first.
- R2: With `lcr_cfg[2]`=0 the stop period is 16 ticks. With `lcr_cfg[2]`=1 it is 24 ticks for 5-bit words and 32 ticks for any other word length. The stop level is high.
- R3: `lcr_cfg[3]`=1 adds a parity bit after the data. When `lcr_cfg[5]`=0, `lcr_cfg[4]`=0 gives odd parity and `lcr_cfg[4]`=1 gives even parity, both counted over the data bits sent. When `lcr_cfg[5]`=1, the parity bit is 1 if `lcr_cfg[4]`=0 and 0 if `lcr_cfg[4]`=1.
- R4: While `lcr_cfg[6]`=1 and reset is low, `tx_line` is 0, even while a character is being shifted. With the break bit clear and no character in progress, `tx_line` is 1.
- R5: `hold_empty` is 1 exactly when `fifo_count` is 0. `xmit_empty` is 1 only when `fifo_count` is 0 and no character is being shifted.
- R6: With `dma_mode1`=0, `txrdy_n` is 0 when `fifo_count` is 0 and 1 when `fifo_count` is nonzero.
- R7: With `dma_mode1`=1, `txrdy_n` is 1 only when `fifo_count` equals the FIFO depth, and 0 whenever at least one slot is free.
- R8: The start, data and parity bits each last 16 `tick16` pulses. The line state does not advance in cycles without a tick.
- R9: While idle with `fifo_count` nonzero, the block pops the head byte on the next clock. At the tick that ends a stop period, it pops the next byte if one is waiting. This sends characters back to back with no idle gap. The block pops only when `fifo_count` is nonzero, and never in two consecutive cycles.
- R10: While reset is high, `tx_line` is 1. After reset the block is idle, with `tx_line`=1, `hold_empty`=1, `xmit_empty`=1, and `txrdy_n`=0 in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| lcr_cfg | input | 7 | Line control: [1:0] word length, [2] long stop, [3] parity on, [4] parity select, [5] forced parity, [6] break |
| dma_mode1 | input | 1 | Selects DMA ready rule: 0 = mode 0, 1 = mode 1 |
| fifo_rd_data | input | 8 | Head byte of the transmit FIFO |
| fifo_count | input | CNT_W (5) | Number of bytes in the transmit FIFO |
| fifo_pop | output | 1 | One-cycle strobe that removes the head byte |
| tx_line | output | 1 | Serial output |
| hold_empty | output | 1 | Transmit FIFO empty |
| xmit_empty | output | 1 | FIFO and shifter both empty |
| txrdy_n | output | 1 | DMA transmit-ready, active low |

## Verification
Some rules are checked on every cycle:
- the break override and the idle level;
- the ordering between the two empty flags;
- the mode-1 ready rule at full and non-full occupancy;
- the pop only when data is present and never twice in a row;
- the line holding still in cycles with no tick and no load.

Other behaviour can only be shown by the bench scenarios:
- the bit order on the line;
- the parity values;
- the exact stop lengths, measured as the spacing between back-to-back characters;
- the sixteen-tick bit width under a slowed tick;
- the mode-0 ready transitions.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int TICK_W        = $clog2(2 * TICKS_PER_BIT + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef struct packed {
        logic [3:0]        data_bits;
        logic              par_en;
        logic              par_sel;
        logic              par_force;
        logic [TICK_W-1:0] stop_ticks;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_fmt(input logic [5:0] f);
        frame_cfg_t c;
        c.data_bits = 4'd5 + {2'b00, f[1:0]};
        c.par_en    = f[3];
        c.par_sel   = f[4];
        c.par_force = f[5];
        if (!f[2])
            c.stop_ticks = TICK_W'(TICKS_PER_BIT);
        else if (f[1:0] == 2'b00)
            c.stop_ticks = TICK_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
        else
            c.stop_ticks = TICK_W'(2 * TICKS_PER_BIT);
        return c;
    endfunction

    function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0] mask;
        logic       ones_odd;
        mask     = 8'hFF >> (4'd8 - c.data_bits);
        ones_odd = ^(d & mask);
        if (c.par_force)
            return ~c.par_sel;
        return c.par_sel ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/tx_char_sequencer.sv
module tx_char_sequencer
    import serial_tx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  frame_cfg_t       cfg_now,
    input  logic [7:0]       head_data,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             pop,
    output logic             ser_bit,
    output logic             busy
);

    tx_phase_e         phase_q;
    logic [7:0]        shreg_q;
    logic [2:0]        bit_idx_q;
    logic [TICK_W-1:0] tcnt_q;
    logic              par_q;
    logic [3:0]        data_bits_q;
    logic              par_en_q;
    logic [TICK_W-1:0] stop_ticks_q;

    logic              have_data;
    logic [TICK_W-1:0] phase_len;
    logic              phase_end;
    logic              last_bit;
    logic              load;

    always_comb begin
        have_data = (fifo_count != '0);
        phase_len = (phase_q == PH_STOP) ? stop_ticks_q : TICK_W'(TICKS_PER_BIT);
        phase_end = tick16 && (tcnt_q == phase_len - TICK_W'(1));
        last_bit  = ({1'b0, bit_idx_q} == data_bits_q - 4'd1);
        load      = have_data &&
                    ((phase_q == PH_IDLE) || ((phase_q == PH_STOP) && phase_end));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            shreg_q      <= '0;
            bit_idx_q    <= '0;
            tcnt_q       <= '0;
            par_q        <= 1'b0;
            data_bits_q  <= 4'd8;
            par_en_q     <= 1'b0;
            stop_ticks_q <= TICK_W'(TICKS_PER_BIT);
        end else if (load) begin
            phase_q      <= PH_START;
            shreg_q      <= head_data;
            bit_idx_q    <= '0;
            tcnt_q       <= '0;
            par_q        <= parity_of(head_data, cfg_now);
            data_bits_q  <= cfg_now.data_bits;
            par_en_q     <= cfg_now.par_en;
            stop_ticks_q <= cfg_now.stop_ticks;
        end else if (phase_end) begin
            tcnt_q <= '0;
            unique case (phase_q)
                PH_START:  phase_q <= PH_DATA;
                PH_DATA: begin
                    shreg_q <= {1'b0, shreg_q[7:1]};
                    if (last_bit)
                        phase_q <= par_en_q ? PH_PARITY : PH_STOP;
                    else
                        bit_idx_q <= bit_idx_q + 3'd1;
                end
                PH_PARITY: phase_q <= PH_STOP;
                PH_STOP:   phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end else if (tick16 && (phase_q != PH_IDLE)) begin
            tcnt_q <= tcnt_q + TICK_W'(1);
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_START:  ser_bit = 1'b0;
            PH_DATA:   ser_bit = shreg_q[0];
            PH_PARITY: ser_bit = par_q;
            default:   ser_bit = 1'b1;
        endcase
    end

    assign pop  = load;
    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/tx_ready_flags.sv
module tx_ready_flags #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             busy,
    input  logic             dma_mode1,
    output logic             hold_empty,
    output logic             xmit_empty,
    output logic             txrdy_n
);

    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(DEPTH);

    logic none_queued;

    always_comb begin
        none_queued = (fifo_count == '0);
        hold_empty  = none_queued;
        xmit_empty  = none_queued && !busy;
        if (dma_mode1)
            txrdy_n = (fifo_count == FULL_COUNT);
        else
            txrdy_n = !none_queued;
    end

endmodule

// File: rtl/tx_line_gate.sv
module tx_line_gate (
    input  logic rst,
    input  logic brk,
    input  logic ser_bit,
    output logic tx_line
);

    always_comb begin
        if (rst)
            tx_line = 1'b1;
        else if (brk)
            tx_line = 1'b0;
        else
            tx_line = ser_bit;
    end

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
    import serial_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  logic [6:0]       lcr_cfg,
    input  logic             dma_mode1,
    input  logic [7:0]       fifo_rd_data,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             fifo_pop,
    output logic             tx_line,
    output logic             hold_empty,
    output logic             xmit_empty,
    output logic             txrdy_n
);

    frame_cfg_t fmt_now;
    logic       ser_bit;
    logic       busy;

    assign fmt_now = decode_fmt(lcr_cfg[5:0]);

    tx_char_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick16     (tick16),
        .cfg_now    (fmt_now),
        .head_data  (fifo_rd_data),
        .fifo_count (fifo_count),
        .pop        (fifo_pop),
        .ser_bit    (ser_bit),
        .busy       (busy)
    );

    tx_ready_flags #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_flags (
        .fifo_count (fifo_count),
        .busy       (busy),
        .dma_mode1  (dma_mode1),
        .hold_empty (hold_empty),
        .xmit_empty (xmit_empty),
        .txrdy_n    (txrdy_n)
    );

    tx_line_gate u_gate (
        .rst     (rst),
        .brk     (lcr_cfg[6]),
        .ser_bit (ser_bit),
        .tx_line (tx_line)
    );

endmodule

// File: rtl/serial_char_tx_chk.sv
module serial_char_tx_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             tick16,
    input logic [6:0]       lcr_cfg,
    input logic             dma_mode1,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_pop,
    input logic             tx_line,
    input logic             hold_empty,
    input logic             xmit_empty,
    input logic             txrdy_n
);

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        lcr_cfg[6] |-> !tx_line); // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (xmit_empty && !lcr_cfg[6]) |-> tx_line); // R4

    AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (rst)
        xmit_empty |-> hold_empty); // R5

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (fifo_count != '0) |-> !hold_empty); // R5

    AST_DMA1_FULL: assert property (@(posedge clk) disable iff (rst)
        (dma_mode1 && (fifo_count == CNT_W'(FIFO_DEPTH))) |-> txrdy_n); // R7

    AST_DMA1_ROOM: assert property (@(posedge clk) disable iff (rst)
        (dma_mode1 && (fifo_count < CNT_W'(FIFO_DEPTH))) |-> !txrdy_n); // R7

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick16 && !fifo_pop) ##1 $stable(lcr_cfg[6]) |-> $stable(tx_line)); // R8

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_count != '0)); // R9

    AST_POP_SPACED: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        ($past(rst) && !rst && !lcr_cfg[6]) |-> (tx_line && xmit_empty)); // R10

endmodule

bind serial_char_tx serial_char_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick16     (tick16),
    .lcr_cfg    (lcr_cfg),
    .dma_mode1  (dma_mode1),
    .fifo_count (fifo_count),
    .fifo_pop   (fifo_pop),
    .tx_line    (tx_line),
    .hold_empty (hold_empty),
    .xmit_empty (xmit_empty),
    .txrdy_n    (txrdy_n)
);

// File: tb/serial_char_tx_tb.sv
module serial_char_tx_tb;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct {
        int data;
        int wl;
        int pen;
        int pbit;
        int len;
        bit chk_gap;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick16;
    logic [6:0]    lcr_r;
    logic          dma_r;
    logic [7:0]    fifo_rd_data;
    logic [CW-1:0] fcnt;
    logic          fifo_pop, tx_line, hold_empty, xmit_empty, txrdy_n;

    logic [7:0] fmem [DEPTH];
    logic [3:0] rp, wp;
    logic       push_v;
    logic [7:0] push_d;
    int         tick_mode;
    logic       tick_ph;
    bit         mon_en;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         fin = 0;
    exp_t       sb_q[$];

    always #4 clk = ~clk;

    serial_char_tx #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick16       (tick16),
        .lcr_cfg      (lcr_r),
        .dma_mode1    (dma_r),
        .fifo_rd_data (fifo_rd_data),
        .fifo_count   (fcnt),
        .fifo_pop     (fifo_pop),
        .tx_line      (tx_line),
        .hold_empty   (hold_empty),
        .xmit_empty   (xmit_empty),
        .txrdy_n      (txrdy_n)
    );

    // behavioural FIFO feeding the block
    always @(posedge clk) begin
        cyc <= cyc + 1;
        tick_ph <= rst ? 1'b0 : ~tick_ph;
        if (rst) begin
            fcnt <= '0; rp <= '0; wp <= '0;
        end else begin
            if (push_v) begin fmem[wp] <= push_d; wp <= wp + 4'd1; end
            if (fifo_pop) rp <= rp + 4'd1;
            fcnt <= fcnt + CW'(push_v) - CW'(fifo_pop);
        end
    end
    assign fifo_rd_data = fmem[rp];
    assign tick16 = (tick_mode == 1) || ((tick_mode == 2) && tick_ph);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [7:0] d, input logic [6:0] c, input bit gap);
        exp_t e;
        int ones, stop;
        e.wl   = 5 + int'(c[1:0]);
        e.data = int'(d) & ((1 << e.wl) - 1);
        e.pen  = int'(c[3]);
        ones   = $countones(e.data);
        if (c[5])      e.pbit = c[4] ? 0 : 1;
        else if (c[4]) e.pbit = ones % 2;
        else           e.pbit = 1 - (ones % 2);
        stop = !c[2] ? 16 : ((c[1:0] == 2'b00) ? 24 : 32);
        e.len = 16 * (1 + e.wl + e.pen) + stop;
        e.chk_gap = gap;
        return e;
    endfunction

    // monitor: decodes each character and compares with the scoreboard
    initial begin : monitor
        exp_t e;
        int t0, prev_t0, prev_len, got;
        prev_t0 = 0; prev_len = 0;
        forever begin
            @(negedge clk);
            if (mon_en && !rst && tx_line == 1'b0) begin
                t0 = cyc;
                if (sb_q.size() == 0) begin
                    check(0, "R1 unexpected character", 0, 1);
                    while (tx_line == 1'b0) @(negedge clk);
                end else begin
                    e = sb_q.pop_front();
                    if (e.chk_gap)
                        check(t0 - prev_t0 == prev_len, "R9 back-to-back spacing (R2 stop length)",
                              t0 - prev_t0, prev_len);
                    repeat (8) @(negedge clk);
                    check(tx_line == 1'b0, "R1 start bit low", int'(tx_line), 0);
                    got = 0;
                    for (int k = 0; k < e.wl; k++) begin
                        repeat (16) @(negedge clk);
                        got = got | (int'(tx_line) << k);
                    end
                    check(got == e.data, "R1 data bits LSB first", got, e.data);
                    if (e.pen != 0) begin
                        repeat (16) @(negedge clk);
                        check(int'(tx_line) == e.pbit, "R3 parity bit", int'(tx_line), e.pbit);
                    end
                    repeat (16) @(negedge clk);
                    check(tx_line == 1'b1, "R2 stop level", int'(tx_line), 1);
                    prev_t0 = t0;
                    prev_len = e.len;
                end
            end
        end
    end

    task automatic wait_idle();
        int g = 0;
        do begin @(negedge clk); g++; end
        while (!(xmit_empty && fcnt == '0) && g < 20000);
        repeat (4) @(negedge clk);
    endtask

    task automatic burst(input logic [6:0] cfg, input int n, input int seed);
        @(negedge clk);
        lcr_r = cfg;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_v = 1'b1;
            push_d = 8'(seed * 37 + i * 91 + 5);
            sb_q.push_back(mk(push_d, cfg, i > 0));
        end
        @(negedge clk);
        push_v = 1'b0;
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lows, ticks, g;
        rst = 1'b1; tick_mode = 1; dma_r = 1'b0; lcr_r = 7'h43;
        push_v = 1'b0; push_d = '0; mon_en = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_line == 1'b1, "R10 line high during reset with break set", int'(tx_line), 1);
        lcr_r = 7'h03;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R10 idle line", int'(tx_line), 1);
        check(hold_empty == 1'b1, "R10 hold_empty", int'(hold_empty), 1);
        check(xmit_empty == 1'b1, "R10 xmit_empty", int'(xmit_empty), 1);
        check(txrdy_n == 1'b0, "R10 txrdy_n", int'(txrdy_n), 0);
        mon_en = 1'b1;

        // R5 / R6 status around a single byte
        @(negedge clk);
        push_v = 1'b1; push_d = 8'hA5;
        sb_q.push_back(mk(8'hA5, lcr_r, 1'b0));
        @(negedge clk);
        push_v = 1'b0;
        check(hold_empty == 1'b0, "R5 hold_empty after write", int'(hold_empty), 0);
        check(xmit_empty == 1'b0, "R5 xmit_empty after write", int'(xmit_empty), 0);
        check(txrdy_n == 1'b1, "R6 mode0 ready deasserted", int'(txrdy_n), 1);
        @(negedge clk);
        check(fifo_pop == 1'b0 && hold_empty == 1'b1, "R9 byte taken, R5 hold_empty", int'(hold_empty), 1);
        check(xmit_empty == 1'b0, "R5 xmit_empty while shifting", int'(xmit_empty), 0);
        check(txrdy_n == 1'b0, "R6 mode0 ready after load", int'(txrdy_n), 0);
        wait_idle();
        check(xmit_empty == 1'b1, "R5 xmit_empty after frame", int'(xmit_empty), 1);

        // formats (R1 R2 R3 R9)
        burst(7'h03, 4, 1);   // 8 bits, 1 stop
        burst(7'h00, 3, 2);   // 5 bits, 1 stop
        burst(7'h04, 3, 3);   // 5 bits, 1.5 stop
        burst(7'h05, 2, 4);   // 6 bits, 2 stop
        burst(7'h09, 3, 5);   // 6 bits, odd parity
        burst(7'h1A, 3, 6);   // 7 bits, even parity
        burst(7'h1E, 3, 7);   // 7 bits, even parity, 2 stop
        burst(7'h2B, 3, 8);   // 8 bits, parity forced 1
        burst(7'h3B, 3, 9);   // 8 bits, parity forced 0
        burst(7'h0F, 2, 10);  // 8 bits, odd parity, 2 stop
        check(sb_q.size() == 0, "R1 all characters seen", sb_q.size(), 0);

        // R8: slowed tick, count ticks across the start bit
        mon_en = 1'b0; tick_mode = 2; lcr_r = 7'h03;
        @(negedge clk); push_v = 1'b1; push_d = 8'hFF;
        @(negedge clk); push_v = 1'b0;
        g = 0;
        while (tx_line == 1'b1 && g < 100) begin @(negedge clk); g++; end
        ticks = 0;
        while (tx_line == 1'b0 && ticks < 100) begin ticks += int'(tick16); @(negedge clk); end
        check(ticks == 16, "R8 start bit tick count", ticks, 16);
        wait_idle();
        tick_mode = 1;

        // R4: break while idle and during a character
        lcr_r = 7'h43;
        @(negedge clk);
        check(tx_line == 1'b0, "R4 break while idle", int'(tx_line), 0);
        lcr_r = 7'h03;
        @(negedge clk);
        check(tx_line == 1'b1, "R4 idle high after break", int'(tx_line), 1);
        lcr_r = 7'h43;
        @(negedge clk); push_v = 1'b1; push_d = 8'h55;
        @(negedge clk); push_v = 1'b0;
        lows = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); lows += int'(tx_line); end
        check(lows == 0, "R4 break overrides shifting", lows, 0);
        lcr_r = 7'h03;
        wait_idle();
        check(tx_line == 1'b1, "R4 idle high", int'(tx_line), 1);

        // R7 / R8 with ticks stopped
        tick_mode = 0; dma_r = 1'b1;
        @(negedge clk);
        check(txrdy_n == 1'b0, "R7 mode1 ready with room", int'(txrdy_n), 0);
        for (int i = 0; i < DEPTH + 1; i++) begin
            @(negedge clk); push_v = 1'b1; push_d = 8'(i);
        end
        @(negedge clk); push_v = 1'b0;
        check(int'(fcnt) == DEPTH && txrdy_n == 1'b1, "R7 mode1 ready high when full", int'(txrdy_n), 1);
        dma_r = 1'b0;
        @(negedge clk);
        check(txrdy_n == 1'b1, "R6 mode0 ready high with data queued", int'(txrdy_n), 1);
        repeat (100) @(negedge clk);
        check(tx_line == 1'b0, "R8 no advance without tick", int'(tx_line), 0);
        dma_r = 1'b1; tick_mode = 1;
        g = 0;
        while (int'(fcnt) == DEPTH && g < 1000) begin @(negedge clk); g++; end
        check(txrdy_n == 1'b0, "R7 mode1 ready after one slot frees", int'(txrdy_n), 0);

        // R10: reset mid-transfer
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; dma_r = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1 && xmit_empty == 1'b1, "R10 reset during transfer", int'(tx_line), 1);
        check(hold_empty == 1'b1 && txrdy_n == 1'b0, "R10 flags after reset", int'(txrdy_n), 0);

        if (!fin) begin
            fin = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule